// File: doc/BRIEF.md
# Serial Configuration Register Slave

This block receives configuration writes from a three-wire synchronous serial bus: a serial clock, a bidirectional data line and an alignment line. All three inputs are brought into the system clock domain through two-flop synchronizers. The serial clock runs at least an order of magnitude slower than the system clock, so it is oversampled. Each rising edge of the synchronized serial clock shifts in one data bit. Bytes are eight bits long, arrive least-significant bit first and carry no parity.

Byte roles alternate. The first byte after the alignment line is asserted is a register address, the next is the data for that address, and the pattern repeats. There are no start or stop conditions. The alignment line is the only means of restoring the address/data pairing after a partial or lost byte.

The received data lands in a small bank of write-only configuration registers, and their fields drive the noise-reduction datapath as plain outputs:
- a filter-strength code;
- a set of control flags;
- an estimator sensitivity value;
- an external noise threshold;
- a pre-filter gain select.

The block never reads back, so the data-line driver it provides is held inactive.

Top module: `sercfg_slave`

## Requirements
- R1: A byte is eight data bits with no parity, taken in arrival order from bit 0 up to bit 7. Each bit is sampled on a 0-to-1 transition of the synchronized serial clock.
- R2: Each serial input passes through two system-clock flops before use. A write takes effect on the fourth system-clock edge after the serial clock edge that carries its final bit, and not earlier.
- R3: While the alignment line is high, a partly received byte is discarded. The first full byte after it is released is an address, and bytes alternate address, data, address, data after that.
- R4: A write to address 0xF3 whose low nibble is 0000, 0010, 0100, 0110 or 1000 loads that nibble into `nr_mode`. In that field, 0000 means filtering off and the other four codes select strengths 1 to 4. The upper nibble of the data byte is ignored.
- R5: A write to 0xF3 with any other low-nibble code leaves `nr_mode` unchanged, so `nr_mode` only ever holds one of the five legal codes.
- R6: A write to 0xF4 sets the control flags from the data byte as follows. Bit 0 goes to `we_late`, bit 1 to `demo_split`, bit 2 to `weave_off` and bit 3 to `ext_thr_sel`. Bits 7:5 go to `test_ctrl[2:0]`. Bit 4 is ignored.
- R7: A write to 0xF5 loads `est_sens` with all eight data bits, and a write to 0xF9 loads `ext_thr` with all eight data bits.
- R8: A write to 0xFA loads `pf_gain` from data bits 7:6. The codes are 00 for unity gain, 01 for half, 10 for quarter and 11 for pre-filter bypass. Bits 5:0 are ignored.
- R9: A write to any address other than 0xF3, 0xF4, 0xF5, 0xF9 and 0xFA changes no output. Outputs change only as the result of a completed data byte.
- R10: An asynchronous reset clears every configuration output to zero. This selects filtering off, the internal threshold and unity pre-filter gain, and it restarts byte alignment.
- R11: The block never drives the data line: `ser_dat_oe` and `ser_dat_o` stay low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously by the caller |
| ser_clk_i | input | 1 | Serial bus clock, asynchronous |
| ser_dat_i | input | 1 | Serial data line, input side |
| ser_align_i | input | 1 | Alignment line, active high; the next byte is an address |
| ser_dat_o | output | 1 | Serial data line, output value |
| ser_dat_oe | output | 1 | Serial data line, output enable |
| nr_mode | output | 4 | Filter strength code |
| we_late | output | 1 | Write-enable timing select |
| demo_split | output | 1 | Split-screen demonstration enable |
| weave_off | output | 1 | Weave disable |
| ext_thr_sel | output | 1 | Use the external threshold instead of the estimator |
| test_ctrl | output | 3 | Test control bits |
| est_sens | output | 8 | Estimator sensitivity value |
| ext_thr | output | 8 | External noise threshold |
| pf_gain | output | 2 | Estimator pre-filter gain select |

## Verification
The bench builds the block with its default two-stage synchronizers and drives the serial clock at four system clocks per half period. At that rate a complete address/data pair costs about 134 cycles. This makes it affordable to sweep the full control range:
- all 256 values of the control-flag register;
- all 16 codes of the mode nibble, each following a known legal value;
- every one of the 251 unassigned addresses.

A single-edge-timed write pins the synchronizer latency to the exact cycle. Truncated bytes followed by an alignment pulse show that the address/data pairing is restored.

// File: rtl/sercfg_pkg.sv
package sercfg_pkg;

  localparam int BYTE_W = 8;
  localparam int CNT_W  = $clog2(BYTE_W);
  localparam int CODE_W = 4;

  localparam logic [BYTE_W-1:0] ADR_MODE = 8'hF3;
  localparam logic [BYTE_W-1:0] ADR_CTRL = 8'hF4;
  localparam logic [BYTE_W-1:0] ADR_SENS = 8'hF5;
  localparam logic [BYTE_W-1:0] ADR_THR  = 8'hF9;
  localparam logic [BYTE_W-1:0] ADR_GAIN = 8'hFA;

  typedef enum logic {
    PH_ADDR = 1'b0,
    PH_DATA = 1'b1
  } phase_e;

  function automatic logic mode_code_ok(input logic [CODE_W-1:0] code);
    return (code == 4'h0) || (code == 4'h2) || (code == 4'h4) ||
           (code == 4'h6) || (code == 4'h8);
  endfunction

endpackage

// File: rtl/sercfg_sync.sv
module sercfg_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);

  logic [STAGES-1:0][WIDTH-1:0] stage_q;

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      logic [WIDTH-1:0] stage_d;
      if (s == 0) begin : g_first
        assign stage_d = async_i;
      end else begin : g_next
        assign stage_d = stage_q[s-1];
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[s] <= '0;
        else        stage_q[s] <= stage_d;
      end
    end
  endgenerate

  assign sync_o = stage_q[STAGES-1];

endmodule

// File: rtl/sercfg_deser.sv
module sercfg_deser
  import sercfg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk_s,
  input  logic              sdat_s,
  input  logic              align_s,
  output logic              rise_o,
  output logic [CNT_W-1:0]  bit_cnt_o,
  output phase_e            phase_o,
  output logic              byte_vld_o,
  output logic              wr_stb_o,
  output logic [BYTE_W-1:0] wr_addr_o,
  output logic [BYTE_W-1:0] wr_data_o
);

  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);

  logic              sclk_d_q;
  logic [BYTE_W-2:0] shift_q, shift_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  phase_e            phase_q, phase_d;
  logic [BYTE_W-1:0] addr_q, addr_d;
  logic [BYTE_W-1:0] data_q, data_d;
  logic              stb_q, stb_d;
  logic              vld_q, vld_d;
  logic              rise;
  logic [BYTE_W-1:0] assembled;

  assign rise      = sclk_s & ~sclk_d_q;
  assign assembled = {sdat_s, shift_q};

  always_comb begin
    shift_d = shift_q;
    cnt_d   = cnt_q;
    phase_d = phase_q;
    addr_d  = addr_q;
    data_d  = data_q;
    stb_d   = 1'b0;
    vld_d   = 1'b0;
    if (align_s) begin
      shift_d = '0;
      cnt_d   = '0;
      phase_d = PH_ADDR;
    end else if (rise) begin
      shift_d = assembled[BYTE_W-1:1];
      if (cnt_q == LAST_BIT) begin
        cnt_d = '0;
        vld_d = 1'b1;
        if (phase_q == PH_ADDR) begin
          addr_d  = assembled;
          phase_d = PH_DATA;
        end else begin
          data_d  = assembled;
          stb_d   = 1'b1;
          phase_d = PH_ADDR;
        end
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_d_q <= 1'b0;
      shift_q  <= '0;
      cnt_q    <= '0;
      phase_q  <= PH_ADDR;
      addr_q   <= '0;
      data_q   <= '0;
      stb_q    <= 1'b0;
      vld_q    <= 1'b0;
    end else begin
      sclk_d_q <= sclk_s;
      shift_q  <= shift_d;
      cnt_q    <= cnt_d;
      phase_q  <= phase_d;
      addr_q   <= addr_d;
      data_q   <= data_d;
      stb_q    <= stb_d;
      vld_q    <= vld_d;
    end
  end

  assign rise_o     = rise;
  assign bit_cnt_o  = cnt_q;
  assign phase_o    = phase_q;
  assign byte_vld_o = vld_q;
  assign wr_stb_o   = stb_q;
  assign wr_addr_o  = addr_q;
  assign wr_data_o  = data_q;

endmodule

// File: rtl/sercfg_regs.sv
module sercfg_regs
  import sercfg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_stb,
  input  logic [BYTE_W-1:0] wr_addr,
  input  logic [BYTE_W-1:0] wr_data,
  output logic [CODE_W-1:0] mode_o,
  output logic              we_late_o,
  output logic              demo_o,
  output logic              weave_off_o,
  output logic              ext_sel_o,
  output logic [2:0]        test_o,
  output logic [BYTE_W-1:0] sens_o,
  output logic [BYTE_W-1:0] thr_o,
  output logic [1:0]        gain_o
);

  logic en_mode, en_ctrl, en_sens, en_thr, en_gain;

  logic [CODE_W-1:0] mode_q, mode_d;
  logic              we_q, we_d, demo_q, demo_d, weave_q, weave_d, ext_q, ext_d;
  logic [2:0]        test_q, test_d;
  logic [BYTE_W-1:0] sens_q, sens_d, thr_q, thr_d;
  logic [1:0]        gain_q, gain_d;

  always_comb begin
    en_mode = wr_stb && (wr_addr == ADR_MODE) && mode_code_ok(wr_data[CODE_W-1:0]);
    en_ctrl = wr_stb && (wr_addr == ADR_CTRL);
    en_sens = wr_stb && (wr_addr == ADR_SENS);
    en_thr  = wr_stb && (wr_addr == ADR_THR);
    en_gain = wr_stb && (wr_addr == ADR_GAIN);
  end

  always_comb begin
    mode_d  = en_mode ? wr_data[CODE_W-1:0] : mode_q;
    we_d    = en_ctrl ? wr_data[0] : we_q;
    demo_d  = en_ctrl ? wr_data[1] : demo_q;
    weave_d = en_ctrl ? wr_data[2] : weave_q;
    ext_d   = en_ctrl ? wr_data[3] : ext_q;
    test_d  = en_ctrl ? wr_data[7:5] : test_q;
    sens_d  = en_sens ? wr_data : sens_q;
    thr_d   = en_thr  ? wr_data : thr_q;
    gain_d  = en_gain ? wr_data[7:6] : gain_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= '0;
      we_q    <= 1'b0;
      demo_q  <= 1'b0;
      weave_q <= 1'b0;
      ext_q   <= 1'b0;
      test_q  <= '0;
      sens_q  <= '0;
      thr_q   <= '0;
      gain_q  <= '0;
    end else begin
      mode_q  <= mode_d;
      we_q    <= we_d;
      demo_q  <= demo_d;
      weave_q <= weave_d;
      ext_q   <= ext_d;
      test_q  <= test_d;
      sens_q  <= sens_d;
      thr_q   <= thr_d;
      gain_q  <= gain_d;
    end
  end

  assign mode_o      = mode_q;
  assign we_late_o   = we_q;
  assign demo_o      = demo_q;
  assign weave_off_o = weave_q;
  assign ext_sel_o   = ext_q;
  assign test_o      = test_q;
  assign sens_o      = sens_q;
  assign thr_o       = thr_q;
  assign gain_o      = gain_q;

endmodule

// File: rtl/sercfg_slave.sv
module sercfg_slave
  import sercfg_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ser_clk_i,
  input  logic              ser_dat_i,
  input  logic              ser_align_i,
  output logic              ser_dat_o,
  output logic              ser_dat_oe,
  output logic [CODE_W-1:0] nr_mode,
  output logic              we_late,
  output logic              demo_split,
  output logic              weave_off,
  output logic              ext_thr_sel,
  output logic [2:0]        test_ctrl,
  output logic [BYTE_W-1:0] est_sens,
  output logic [BYTE_W-1:0] ext_thr,
  output logic [1:0]        pf_gain
);

  localparam int N_SYNC = 3;

  logic [N_SYNC-1:0] sync_vec;
  logic              sclk_s, sdat_s, align_s;
  logic              rise;
  logic [CNT_W-1:0]  bit_cnt;
  phase_e            phase;
  logic              byte_vld;
  logic              wr_stb;
  logic [BYTE_W-1:0] wr_addr, wr_data;

  sercfg_sync #(
    .WIDTH  (N_SYNC),
    .STAGES (SYNC_STAGES)
  ) i_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_i ({ser_align_i, ser_dat_i, ser_clk_i}),
    .sync_o  (sync_vec)
  );

  assign sclk_s  = sync_vec[0];
  assign sdat_s  = sync_vec[1];
  assign align_s = sync_vec[2];

  sercfg_deser i_deser (
    .clk        (clk),
    .rst_n      (rst_n),
    .sclk_s     (sclk_s),
    .sdat_s     (sdat_s),
    .align_s    (align_s),
    .rise_o     (rise),
    .bit_cnt_o  (bit_cnt),
    .phase_o    (phase),
    .byte_vld_o (byte_vld),
    .wr_stb_o   (wr_stb),
    .wr_addr_o  (wr_addr),
    .wr_data_o  (wr_data)
  );

  sercfg_regs i_regs (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_stb      (wr_stb),
    .wr_addr     (wr_addr),
    .wr_data     (wr_data),
    .mode_o      (nr_mode),
    .we_late_o   (we_late),
    .demo_o      (demo_split),
    .weave_off_o (weave_off),
    .ext_sel_o   (ext_thr_sel),
    .test_o      (test_ctrl),
    .sens_o      (est_sens),
    .thr_o       (ext_thr),
    .gain_o      (pf_gain)
  );

  assign ser_dat_o  = 1'b0;
  assign ser_dat_oe = 1'b0;

endmodule

// File: rtl/sercfg_checker.sv
module sercfg_checker
  import sercfg_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ser_clk_i,
  input logic              sclk_s,
  input logic              align_s,
  input logic              rise,
  input logic [CNT_W-1:0]  bit_cnt,
  input logic              phase,
  input logic              byte_vld,
  input logic              wr_stb,
  input logic [CODE_W-1:0] nr_mode,
  input logic [30:0]       cfg_vec
);

  logic [1:0] age_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                age_q <= '0;
    else if (age_q != 2'd3)    age_q <= age_q + 2'd1;
  end

  AST_BYTE_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
    byte_vld |-> (bit_cnt == '0)); // R1

  AST_NO_DOUBLE_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> !rise); // R1

  generate
    if (SYNC_STAGES == 2) begin : g_lat
      AST_SYNC_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        (age_q >= 2'd2) |-> (sclk_s == $past(ser_clk_i, 2))); // R2
    end
  endgenerate

  AST_ALIGN_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    align_s |=> ((bit_cnt == '0) && (phase == 1'b0))); // R3

  AST_WRITE_ENDS_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |-> (phase == 1'b0)); // R3

  AST_MODE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    mode_code_ok(nr_mode)); // R5

  AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_stb |=> $stable(cfg_vec)); // R9

endmodule

bind sercfg_slave sercfg_checker #(
  .SYNC_STAGES (SYNC_STAGES)
) i_checker (
  .clk       (clk),
  .rst_n     (rst_n),
  .ser_clk_i (ser_clk_i),
  .sclk_s    (sclk_s),
  .align_s   (align_s),
  .rise      (rise),
  .bit_cnt   (bit_cnt),
  .phase     (phase),
  .byte_vld  (byte_vld),
  .wr_stb    (wr_stb),
  .nr_mode   (nr_mode),
  .cfg_vec   ({nr_mode, we_late, demo_split, weave_off, ext_thr_sel,
               test_ctrl, est_sens, ext_thr, pf_gain})
);

// File: tb/test_sercfg_slave.sv
module test_sercfg_slave;

  localparam int HP = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ser_clk_i = 1'b0;
  logic       ser_dat_i = 1'b0;
  logic       ser_align_i = 1'b0;
  logic       ser_dat_o, ser_dat_oe;
  logic [3:0] nr_mode;
  logic       we_late, demo_split, weave_off, ext_thr_sel;
  logic [2:0] test_ctrl;
  logic [7:0] est_sens, ext_thr;
  logic [1:0] pf_gain;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 1'b0;

  logic [3:0] e_mode;
  logic [7:0] e_ctrl, e_sens, e_thr;
  logic [1:0] e_gain;

  always #5 clk = ~clk;

  sercfg_slave i_sercfg_slave (
    .clk         (clk),
    .rst_n       (rst_n),
    .ser_clk_i   (ser_clk_i),
    .ser_dat_i   (ser_dat_i),
    .ser_align_i (ser_align_i),
    .ser_dat_o   (ser_dat_o),
    .ser_dat_oe  (ser_dat_oe),
    .nr_mode     (nr_mode),
    .we_late     (we_late),
    .demo_split  (demo_split),
    .weave_off   (weave_off),
    .ext_thr_sel (ext_thr_sel),
    .test_ctrl   (test_ctrl),
    .est_sens    (est_sens),
    .ext_thr     (ext_thr),
    .pf_gain     (pf_gain)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic check_all(input string tag);
    check({tag, " R4 mode"}, 32'(nr_mode), 32'(e_mode));
    check({tag, " R6 flags"}, {28'd0, ext_thr_sel, weave_off, demo_split, we_late},
          {28'd0, e_ctrl[3:0]});
    check({tag, " R6 test"}, 32'(test_ctrl), 32'(e_ctrl[7:5]));
    check({tag, " R7 sens"}, 32'(est_sens), 32'(e_sens));
    check({tag, " R7 thr"}, 32'(ext_thr), 32'(e_thr));
    check({tag, " R8 gain"}, 32'(pf_gain), 32'(e_gain));
    check({tag, " R11 drive"}, {30'd0, ser_dat_oe, ser_dat_o}, 32'd0);
  endtask

  task automatic send_bit(input logic b);
    @(negedge clk);
    ser_dat_i = b;
    ser_clk_i = 1'b0;
    repeat (HP) @(negedge clk);
    ser_clk_i = 1'b1;
    repeat (HP - 1) @(negedge clk);
  endtask

  task automatic send_byte(input logic [7:0] v);
    for (int i = 0; i < 8; i++) send_bit(v[i]);
  endtask

  task automatic write(input logic [7:0] a, input logic [7:0] d);
    send_byte(a);
    send_byte(d);
    @(negedge clk);
    ser_clk_i = 1'b0;
    repeat (6) @(negedge clk);
  endtask

  task automatic pulse_align();
    @(negedge clk);
    ser_clk_i   = 1'b0;
    ser_align_i = 1'b1;
    repeat (4) @(negedge clk);
    ser_align_i = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  function automatic logic legal(input logic [3:0] c);
    return (c == 4'h0) || (c == 4'h2) || (c == 4'h4) || (c == 4'h6) || (c == 4'h8);
  endfunction

  function automatic logic known_addr(input logic [7:0] a);
    return (a == 8'hF3) || (a == 8'hF4) || (a == 8'hF5) || (a == 8'hF9) || (a == 8'hFA);
  endfunction

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_err++;
      n_chk++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    e_mode = '0; e_ctrl = '0; e_sens = '0; e_thr = '0; e_gain = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check_all("R10 reset");

    // R4 R5: every mode nibble, upper nibble ignored
    write(8'hF3, 8'h04); e_mode = 4'h4;
    check_all("R4 seed");
    for (int c = 0; c < 16; c++) begin
      write(8'hF3, {4'(c) ^ 4'h5, 4'(c)});
      if (legal(4'(c))) begin
        e_mode = 4'(c);
        check_all("R4 legal code");
      end else begin
        check_all("R5 illegal code kept");
      end
      write(8'hF3, 8'h06); e_mode = 4'h6;
    end

    // R6: full sweep of the flag register
    for (int v = 0; v < 256; v++) begin
      write(8'hF4, 8'(v)); e_ctrl = 8'(v);
      check_all("R6 flags");
    end

    // R1 R7: data bits in arrival order
    for (int v = 0; v < 256; v += 3) begin
      write(8'hF5, 8'(v)); e_sens = 8'(v);
      write(8'hF9, 8'(v) ^ 8'hFF); e_thr = 8'(v) ^ 8'hFF;
      check_all("R1 R7 values");
    end
    write(8'hF5, 8'h01); e_sens = 8'h01;
    check_all("R1 lsb first");
    write(8'hF9, 8'h80); e_thr = 8'h80;
    check_all("R1 msb last");

    // R8: gain codes with noisy low bits
    for (int g = 0; g < 4; g++) begin
      write(8'hFA, {2'(g), 6'b101101}); e_gain = 2'(g);
      check_all("R8 gain");
    end

    // R9: every unassigned address is ignored
    write(8'hF3, 8'h08); e_mode = 4'h8;
    write(8'hF4, 8'hA5); e_ctrl = 8'hA5;
    write(8'hF5, 8'h3C); e_sens = 8'h3C;
    write(8'hF9, 8'hC3); e_thr = 8'hC3;
    write(8'hFA, 8'h80); e_gain = 2'b10;
    for (int a = 0; a < 256; a++) begin
      if (!known_addr(8'(a))) begin
        write(8'(a), 8'h5A ^ 8'(a));
        check_all("R9 ignored address");
      end
    end

    // R3: truncated byte, then realign
    for (int i = 0; i < 3; i++) send_bit(1'b1);
    pulse_align();
    write(8'hF5, 8'h96); e_sens = 8'h96;
    check_all("R3 after partial byte");
    send_byte(8'hF9);
    pulse_align();
    write(8'hF5, 8'h69); e_sens = 8'h69;
    check_all("R3 after lone address");

    // R2: exact write latency
    send_byte(8'hF9);
    for (int i = 0; i < 7; i++) send_bit(1'b0);
    @(negedge clk);
    ser_dat_i = 1'b1;
    ser_clk_i = 1'b0;
    repeat (HP) @(negedge clk);
    ser_clk_i = 1'b1;
    repeat (3) @(posedge clk);
    #1 check("R2 not before edge 4", 32'(ext_thr), 32'(e_thr));
    @(posedge clk);
    #1 check("R2 at edge 4", 32'(ext_thr), 32'h80);
    e_thr = 8'h80;
    @(negedge clk);
    ser_clk_i = 1'b0;
    repeat (6) @(negedge clk);

    // R10: reset mid run, then alignment restarts
    send_bit(1'b1);
    @(negedge clk);
    rst_n = 1'b0;
    ser_clk_i = 1'b0;
    repeat (2) @(negedge clk);
    e_mode = '0; e_ctrl = '0; e_sens = '0; e_thr = '0; e_gain = '0;
    check_all("R10 mid reset");
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    write(8'hF9, 8'h77); e_thr = 8'h77;
    check_all("R10 realigned");

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

endmodule